// File: doc/BRIEF.md
# Transmit Source Select and Baud Symbol Latch

This block sits in front of a modulator. It picks the serial bit stream to transmit and packs that stream into symbols of two bits (dibit) or four bits (quadbit). The bit comes from one of two places. The first is the serial data input pin. The second is a single data bit that the host writes. A two-bit pattern setting can replace both sources with a fixed stream: all ones, all zeros, or alternating ones and zeros.

All logic runs on one clock, and one bit period lasts `CLKS_PER_BIT` clocks. The block makes a baud clock from this bit timing. On each rising edge of the baud clock it latches one baud's worth of bits into the symbol output and pulses a valid strobe. Incoming data is expected to change half a bit period after the block's own bit frame begins. The block samples each bit on the last clock of its frame, which falls in the middle of that data bit. `quad_mode` is static and is changed only while reset is held. The serial pin is taken to be synchronous to `clk`.

Top module: `txsrc_baud_latch`

## Requirements
- R1: With `tx_pat` = 00, the sampled bit equals `ser_in` when `src_alt` = 0 and equals `host_bit` when `src_alt` = 1. The source that is not selected has no effect on `sym`.
- R2: With `tx_pat` = 01, every sampled bit is 1. With `tx_pat` = 10, every sampled bit is 0. In both cases `ser_in`, `host_bit` and `src_alt` have no effect on `sym`.
- R3: With `tx_pat` = 11, the sampled bit alternates. The first bit sampled after reset is 1, and the alternation advances on every sampled bit whatever the pattern setting.
- R4: Exactly one bit is sampled per bit period. Counting rising edges after reset release as 1, 2, 3, ..., the input is sampled at edges `CLKS_PER_BIT`, 2·`CLKS_PER_BIT`, and so on.
- R5: `quad_mode` = 1 gives 4 bits per baud and `quad_mode` = 0 gives 2 bits per baud. `sym_vld` pulses once every `CLKS_PER_BIT` × bits-per-baud clocks.
- R6: The bit sampled first within a baud goes in the most significant used position. A quadbit fills `sym[3:0]`. A dibit fills `sym[1:0]` and forces `sym[3:2]` to 0.
- R7: `sym_vld` is high for exactly one clock, in the cycle that follows the edge on which `sym` takes a new symbol. At all other times `sym` holds its value.
- R8: `baud_clk` is high while fewer than half the bits of the current baud have been sampled. It rises in the same cycle that `sym_vld` is high.
- R9: While `rst_n` is low, `sym` = 0, `sym_vld` = 0 and `baud_clk` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one bit period is CLKS_PER_BIT cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial transmit data from the pin |
| host_bit | input | 1 | Data bit written by the host |
| src_alt | input | 1 | Source select: 0 takes the pin, 1 takes the host bit |
| tx_pat | input | 2 | Pattern override: 00 data, 01 ones, 10 zeros, 11 alternating |
| quad_mode | input | 1 | 1 selects four bits per baud, 0 selects two |
| baud_clk | output | 1 | Baud clock; its rising edge marks a symbol latch |
| sym | output | SYM_W | Latched symbol, first bit in the most significant used position |
| sym_vld | output | 1 | One-cycle strobe for a newly latched symbol |

## Verification
Each input bit is taken on one edge. The edges are multiples of `CLKS_PER_BIT` after reset, and the bench changes `ser_in` and `host_bit` only half a bit away from those edges. A symbol, its `sym_vld` pulse and the rise of `baud_clk` all appear after the edge that samples the last bit of the baud. With no extra register stage, that is exactly `CLKS_PER_BIT` × bits-per-baud edges after the previous symbol. A behavioural model in the bench updates on the same rising edges and is compared with the outputs on every falling edge, so every result is checked in the cycle where it first becomes visible. Separate checks measure the distance from reset to the first strobe in both modes.

// File: rtl/txsrc_pkg.sv
package txsrc_pkg;

  typedef enum logic [1:0] {
    PAT_DATA  = 2'b00,
    PAT_MARK  = 2'b01,
    PAT_SPACE = 2'b10,
    PAT_ALT   = 2'b11
  } tx_pat_e;

  // Bit that enters the symbol: a fixed pattern wins over either data source.
  function automatic logic pick_bit(input tx_pat_e pat, input logic use_host,
                                    input logic pin_bit, input logic host_bit,
                                    input logic alt_bit);
    logic b;
    unique case (pat)
      PAT_MARK:  b = 1'b1;
      PAT_SPACE: b = 1'b0;
      PAT_ALT:   b = alt_bit;
      default:   b = use_host ? host_bit : pin_bit;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/txsrc_bit_timer.sv
module txsrc_bit_timer #(
  parameter int unsigned CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_end
);
  localparam int unsigned PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_BIT - 1);

  logic [PH_W-1:0] ph_q;

  // The last clock of a frame sits mid-way through a data bit delayed by half a bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign bit_end = (ph_q == PH_LAST);
endmodule

// File: rtl/txsrc_data_sel.sv
module txsrc_data_sel
  import txsrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_end,
  input  logic [1:0] tx_pat,
  input  logic       src_alt,
  input  logic       ser_in,
  input  logic       host_bit,
  output logic       smp_bit
);
  logic alt_q;

  // Alternating source: starts at one, advances on every sampled bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alt_q <= 1'b1;
    else if (bit_end) alt_q <= ~alt_q;
  end

  assign smp_bit = pick_bit(tx_pat_e'(tx_pat), src_alt, ser_in, host_bit, alt_q);
endmodule

// File: rtl/txsrc_symbol_asm.sv
module txsrc_symbol_asm #(
  parameter int unsigned SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_end,
  input  logic             smp_bit,
  input  logic             quad_mode,
  output logic [SYM_W-1:0] sym,
  output logic             sym_vld,
  output logic             baud_clk,
  output logic             baud_rise
);
  localparam int unsigned HALF_W = SYM_W / 2;
  localparam int unsigned CNT_W  = $clog2(SYM_W);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, last_idx, half_idx;
  logic [SYM_W-2:0] sh_q;
  logic [SYM_W-1:0] sym_q;
  logic             vld_q, baud_q;

  function automatic logic [SYM_W-1:0] pack_sym(input logic quad,
                                                input logic [SYM_W-2:0] early,
                                                input logic newest);
    logic [SYM_W-1:0] s;
    if (quad) s = {early, newest};
    else      s = {{HALF_W{1'b0}}, early[HALF_W-2:0], newest};
    return s;
  endfunction

  assign last_idx  = quad_mode ? CNT_W'(SYM_W - 1) : CNT_W'(HALF_W - 1);
  assign half_idx  = quad_mode ? CNT_W'(SYM_W / 2) : CNT_W'(HALF_W / 2);
  assign baud_rise = bit_end && (cnt_q == last_idx);
  assign cnt_nxt   = !bit_end ? cnt_q : (baud_rise ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      sym_q  <= '0;
      vld_q  <= 1'b0;
      baud_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      baud_q <= (cnt_nxt < half_idx);
      vld_q  <= baud_rise;
      if (bit_end)   sh_q  <= {sh_q[SYM_W-3:0], smp_bit};
      if (baud_rise) sym_q <= pack_sym(quad_mode, sh_q, smp_bit);
    end
  end

  assign sym      = sym_q;
  assign sym_vld  = vld_q;
  assign baud_clk = baud_q;
endmodule

// File: rtl/txsrc_baud_latch.sv
module txsrc_baud_latch #(
  parameter int unsigned CLKS_PER_BIT = 8,
  parameter int unsigned SYM_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             host_bit,
  input  logic             src_alt,
  input  logic [1:0]       tx_pat,
  input  logic             quad_mode,
  output logic             baud_clk,
  output logic [SYM_W-1:0] sym,
  output logic             sym_vld
);
  logic bit_end;
  logic smp_bit;
  logic baud_rise;

  txsrc_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_end (bit_end)
  );

  txsrc_data_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_end  (bit_end),
    .tx_pat   (tx_pat),
    .src_alt  (src_alt),
    .ser_in   (ser_in),
    .host_bit (host_bit),
    .smp_bit  (smp_bit)
  );

  txsrc_symbol_asm #(.SYM_W(SYM_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_end   (bit_end),
    .smp_bit   (smp_bit),
    .quad_mode (quad_mode),
    .sym       (sym),
    .sym_vld   (sym_vld),
    .baud_clk  (baud_clk),
    .baud_rise (baud_rise)
  );
endmodule

// File: rtl/txsrc_baud_latch_chk.sv
module txsrc_baud_latch_chk #(
  parameter int unsigned CLKS_PER_BIT = 8,
  parameter int unsigned SYM_W        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_in,
  input logic             host_bit,
  input logic             src_alt,
  input logic [1:0]       tx_pat,
  input logic             quad_mode,
  input logic             baud_clk,
  input logic [SYM_W-1:0] sym,
  input logic             sym_vld,
  input logic             bit_end,
  input logic             smp_bit
);
  localparam int unsigned HALF_W = SYM_W / 2;

  int unsigned gap_q;
  int unsigned period;
  assign period = CLKS_PER_BIT * (quad_mode ? SYM_W : HALF_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 0;
    else        gap_q <= sym_vld ? 1 : gap_q + 1;
  end

  AST_PIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && tx_pat == 2'b00 && !src_alt) |-> smp_bit == ser_in); // R1
  AST_HOST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && tx_pat == 2'b00 && src_alt) |-> smp_bit == host_bit); // R1
  AST_MARK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && tx_pat == 2'b01) |-> smp_bit); // R2
  AST_SPACE_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && tx_pat == 2'b10) |-> !smp_bit); // R2
  AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !bit_end); // R4
  AST_BAUD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> gap_q == period); // R5
  AST_BAUD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= period); // R5
  AST_DIBIT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && !quad_mode) |-> sym[SYM_W-1:HALF_W] == '0); // R6
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> !sym_vld); // R7
  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |-> $stable(sym)); // R7
  AST_RISE_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_clk) |-> sym_vld); // R8
  AST_VLD_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> baud_clk); // R8
endmodule

bind txsrc_baud_latch txsrc_baud_latch_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .SYM_W(SYM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .host_bit(host_bit),
  .src_alt(src_alt), .tx_pat(tx_pat), .quad_mode(quad_mode),
  .baud_clk(baud_clk), .sym(sym), .sym_vld(sym_vld),
  .bit_end(bit_end), .smp_bit(smp_bit)
);

// File: tb/tb_txsrc_baud_latch.sv
module tb_txsrc_baud_latch;
  localparam int CPB = 8;
  localparam int SW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, host_bit = 1'b0, src_alt = 1'b0, quad_mode = 1'b0;
  logic [1:0] tx_pat = 2'b00;
  logic baud_clk, sym_vld;
  logic [SW-1:0] sym;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  txsrc_baud_latch #(.CLKS_PER_BIT(CPB), .SYM_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .host_bit(host_bit),
    .src_alt(src_alt), .tx_pat(tx_pat), .quad_mode(quad_mode),
    .baud_clk(baud_clk), .sym(sym), .sym_vld(sym_vld)
  );

  // Behavioural reference model
  int cyc, nsmp;
  bit q[$];
  logic [SW-1:0] m_sym;
  logic m_vld, m_baud;

  function automatic int bpb();
    return quad_mode ? 4 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; nsmp = 0; q.delete(); m_sym = '0; m_vld = 1'b0; m_baud = 1'b1;
    end else begin
      bit b;
      cyc++;
      m_vld = 1'b0;
      if (cyc % CPB == 0) begin
        case (tx_pat)
          2'b01: b = 1'b1;
          2'b10: b = 1'b0;
          2'b11: b = (nsmp % 2 == 0);
          default: b = src_alt ? host_bit : ser_in;
        endcase
        nsmp++;
        q.push_back(b);
        if (q.size() == bpb()) begin
          m_sym = '0;
          foreach (q[i]) m_sym = {m_sym[SW-2:0], q[i]};
          q.delete();
          m_vld = 1'b1;
        end
      end
      m_baud = ((nsmp % bpb()) < bpb() / 2);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(cur_req, sym, m_sym);
      chk("R7", sym_vld, m_vld);
      chk("R8", baud_clk, m_baud);
      if (sym_vld && !quad_mode) chk("R6", sym[3:2], 0);
    end
  end

  // Data moves half a bit away from the sampling edges.
  task automatic drive(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cyc % CPB == CPB / 2) begin
        ser_in   = 1'($urandom);
        host_bit = 1'($urandom);
      end
    end
  endtask

  task automatic phase(input string req, input logic [1:0] pat, input logic alt, input int n);
    cur_req = req; tx_pat = pat; src_alt = alt;
    drive(n);
  endtask

  task automatic do_reset(input logic quad);
    int k;
    cmp_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; quad_mode = quad; tx_pat = 2'b00; src_alt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", sym, 0);
    chk("R9", sym_vld, 0);
    chk("R9", baud_clk, 1);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    k = 0;
    while (!sym_vld && k < 100) begin
      drive(1);
      k++;
    end
    chk("R4", k, CPB * (quad ? 4 : 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      phase("R1", 2'b00, 1'b0, 400);
      phase("R1", 2'b00, 1'b1, 400);
      phase("R2", 2'b01, 1'b0, 300);
      phase("R2", 2'b10, 1'b1, 300);
      phase("R3", 2'b11, 1'b0, 300);
      phase("R2", 2'b01, 1'b1, 100);
      phase("R3", 2'b11, 1'b1, 300);
      phase(m ? "R5" : "R6", 2'b00, 1'b0, 400);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule